// File: doc/BRIEF.md
# Bilinear-Mapped Fixed-Point PID Controller

This block is a sampled three-term (proportional, integral, derivative) controller. A sample strobe hands it one signed error value. The block then computes one new signed control value and raises a one-cycle valid pulse.

The continuous law uses Tustin (bilinear) substitution for both the integral and the derivative terms. Their combined denominator is 1 − z⁻², so the recursion is

u[n] = u[n−2] + b0·e[n] + b1·e[n−1] + b2·e[n−2]

The recursion runs as a Direct Form I filter, with two error taps and two output taps. The three numerator coefficients are computed offline from the gains and the sample period (the intended period is 1 ms) and written through a small write port.

A single multiplier-accumulator is shared over three cycles. A final cycle adds the output from two samples back and clamps the result to the output width.

Top module: `pid_tustin_ctrl`

## Requirements
- R1: Each accepted sample produces u[n] = sat(u[n−2] + floor((b0·e[n] + b1·e[n−1] + b2·e[n−2]) / 2^FRAC_W)). The products are summed at full precision before a single arithmetic right shift by FRAC_W (default 12).
- R2: The result clamps to the signed U_W range (−32768..32767 by default) instead of wrapping. The clamped value is the one fed back as u[n−1] and u[n−2].
- R3: Coefficient writes use `cf_sel` encoding 0 = b0, 1 = b1, 2 = b2. A write with `cf_sel` = 3 changes nothing.
- R4: A written coefficient is used only from the next accepted strobe onward. A write in the same cycle as a strobe does not affect that sample.
- R5: `u_valid` rises exactly four clock edges after the edge that accepts a strobe, and it stays high for one cycle only.
- R6: A strobe that arrives while a computation is in progress is ignored. It changes neither the delay taps nor the result.
- R7: Synchronous reset clears the delay taps, the coefficient registers, `u_out` and `u_valid` to zero.
- R8: `u_out` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| smp_stb | input | 1 | sample strobe; accepted only when idle |
| e_in | input | E_W | signed error sample |
| cf_we | input | 1 | coefficient write enable |
| cf_sel | input | 2 | coefficient select (0 = b0, 1 = b1, 2 = b2) |
| cf_wdata | input | C_W | signed coefficient, FRAC_W fraction bits |
| u_out | output | U_W | signed control output |
| u_valid | output | 1 | one-cycle pulse when u_out is updated |

## Verification
The bench compares each output with an integer model of the recursion, using step inputs, ramp inputs and sign changes of the error.

Saturation is driven in both directions and then followed by zero-error samples. A design that fed back the unclamped sum, or that wrapped, would give a different later output.

A coefficient written in the same cycle as a strobe catches a design that mixes coefficient sets within one sample. A write with select value 3 catches a design that aliases that value onto b0.

A strobe poked mid-computation catches a restart or a tap shift that should not happen. A reset in the middle of a sequence must leave later outputs as if the history had been zero.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int unsigned COEF_CNT = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MAC0,
        PH_MAC1,
        PH_MAC2,
        PH_OUT
    } pid_phase_e;

    // Sequencer order: three product cycles, then the feedback/clamp cycle.
    function automatic pid_phase_e phase_after(pid_phase_e p);
        case (p)
            PH_MAC0: return PH_MAC1;
            PH_MAC1: return PH_MAC2;
            PH_MAC2: return PH_OUT;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pid_coef_bank.sv
module pid_coef_bank
    import pid_pkg::*;
#(
    parameter int C_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_sel,
    input  logic [C_W-1:0]                    wr_data,
    input  logic                              load,
    output logic [COEF_CNT-1:0][C_W-1:0]      coef_act
);
    logic [COEF_CNT-1:0][C_W-1:0] coef_shd;

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_shd <= '0;
            coef_act <= '0;
        end else begin
            for (int i = 0; i < COEF_CNT; i++) begin
                if (wr_en && (int'(wr_sel) == i))
                    coef_shd[i] <= wr_data;
            end
            if (load)
                coef_act <= coef_shd;
        end
    end
endmodule

// File: rtl/pid_tap2.sv
module pid_tap2 #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift,
    input  logic signed [W-1:0] d,
    output logic signed [W-1:0] q1,
    output logic signed [W-1:0] q2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q1 <= '0;
            q2 <= '0;
        end else if (shift) begin
            q1 <= d;
            q2 <= q1;
        end
    end

    a_r6_taps_hold: assert property (@(posedge clk) disable iff (rst)
        !shift |=> ($stable(q1) && $stable(q2)));
endmodule

// File: rtl/pid_mac.sv
module pid_mac #(
    parameter int A_W   = 16,
    parameter int B_W   = 16,
    parameter int ACC_W = 34
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    accum,
    input  logic signed [A_W-1:0]   a,
    input  logic signed [B_W-1:0]   b,
    output logic signed [ACC_W-1:0] acc
);
    localparam int P_W = A_W + B_W;

    logic signed [P_W-1:0]   prod;
    logic signed [ACC_W-1:0] prod_x;

    always_comb begin
        prod   = a * b;
        prod_x = {{(ACC_W-P_W){prod[P_W-1]}}, prod};
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (start)
            acc <= prod_x;
        else if (accum)
            acc <= acc + prod_x;
    end
endmodule

// File: rtl/pid_sat.sv
module pid_sat #(
    parameter int IN_W  = 35,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

    logic hi_same;

    always_comb begin
        hi_same = (din[IN_W-1:OUT_W-1] == {(IN_W-OUT_W+1){din[IN_W-1]}});
        if (hi_same)
            dout = din[OUT_W-1:0];
        else if (din[IN_W-1])
            dout = MIN_V;
        else
            dout = MAX_V;
    end
endmodule

// File: rtl/pid_tustin_ctrl.sv
module pid_tustin_ctrl
    import pid_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int C_W    = 16,
    parameter int FRAC_W = 12,
    parameter int U_W    = 16,
    parameter int GUARD  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_stb,
    input  logic signed [E_W-1:0] e_in,
    input  logic                  cf_we,
    input  logic [1:0]            cf_sel,
    input  logic signed [C_W-1:0] cf_wdata,
    output logic signed [U_W-1:0] u_out,
    output logic                  u_valid
);
    localparam int ACC_W = C_W + E_W + GUARD;
    localparam int SUM_W = ACC_W + 1;

    pid_phase_e phase;
    logic       accept;
    logic signed [E_W-1:0] e_cur, e_d1, e_d2;
    logic signed [U_W-1:0] u_d1, u_d2, u_new;
    logic [COEF_CNT-1:0][C_W-1:0] coef_act;
    logic signed [C_W-1:0] mac_b;
    logic signed [E_W-1:0] mac_e;
    logic signed [ACC_W-1:0] acc, acc_scl;
    logic signed [SUM_W-1:0] sum;
    logic out_step;

    assign accept   = smp_stb && (phase == PH_IDLE);
    assign out_step = (phase == PH_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            e_cur <= '0;
        end else if (accept) begin
            phase <= PH_MAC0;
            e_cur <= e_in;
        end else begin
            phase <= phase_after(phase);
        end
    end

    pid_coef_bank #(.C_W(C_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(cf_we), .wr_sel(cf_sel),
        .wr_data(cf_wdata), .load(accept), .coef_act(coef_act)
    );

    always_comb begin
        case (phase)
            PH_MAC1: begin mac_b = $signed(coef_act[1]); mac_e = e_d1; end
            PH_MAC2: begin mac_b = $signed(coef_act[2]); mac_e = e_d2; end
            default: begin mac_b = $signed(coef_act[0]); mac_e = e_cur; end
        endcase
    end

    pid_mac #(.A_W(C_W), .B_W(E_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst(rst),
        .start(phase == PH_MAC0),
        .accum((phase == PH_MAC1) || (phase == PH_MAC2)),
        .a(mac_b), .b(mac_e), .acc(acc)
    );

    always_comb begin
        acc_scl = acc >>> FRAC_W;
        sum     = {acc_scl[ACC_W-1], acc_scl} + {{(SUM_W-U_W){u_d2[U_W-1]}}, u_d2};
    end

    pid_sat #(.IN_W(SUM_W), .OUT_W(U_W)) u_sat (.din(sum), .dout(u_new));

    pid_tap2 #(.W(E_W)) u_etap (
        .clk(clk), .rst(rst), .shift(out_step), .d(e_cur), .q1(e_d1), .q2(e_d2)
    );

    pid_tap2 #(.W(U_W)) u_utap (
        .clk(clk), .rst(rst), .shift(out_step), .d(u_new), .q1(u_d1), .q2(u_d2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            u_out   <= '0;
            u_valid <= 1'b0;
        end else begin
            u_valid <= out_step;
            if (out_step)
                u_out <= u_new;
        end
    end

    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAC2) |=> ##1 u_valid);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        u_valid |=> !u_valid);
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && phase != PH_IDLE) |=> (phase != PH_MAC0));
    a_r4_coef_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(coef_act));
    a_r2_feedback_matches: assert property (@(posedge clk) disable iff (rst)
        u_valid |-> (u_out == u_d1));
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !u_valid |=> (u_valid || $stable(u_out)));
endmodule

// File: tb/test_pid_tustin_ctrl.sv
module test_pid_tustin_ctrl;
    localparam int E_W = 16, C_W = 16, FRAC_W = 12, U_W = 16;
    localparam longint UMAX = 32767, UMIN = -32768;

    logic clk = 0, rst = 1, smp_stb = 0, cf_we = 0;
    logic signed [E_W-1:0] e_in = '0;
    logic [1:0] cf_sel = '0;
    logic signed [C_W-1:0] cf_wdata = '0;
    logic signed [U_W-1:0] u_out;
    logic u_valid;

    int total = 0, bad = 0;
    longint sh[3], act[3], eh1, eh2, uh1, uh2;

    always #5 clk = ~clk;

    pid_tustin_ctrl #(.E_W(E_W), .C_W(C_W), .FRAC_W(FRAC_W), .U_W(U_W)) i_pid_tustin_ctrl (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .e_in(e_in), .cf_we(cf_we),
        .cf_sel(cf_sel), .cf_wdata(cf_wdata), .u_out(u_out), .u_valid(u_valid)
    );

    task automatic chk(input bit ok, input string tag, input longint a, input longint x);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, a, x);
        end
    endtask

    task automatic ref_clear();
        for (int i = 0; i < 3; i++) begin sh[i] = 0; act[i] = 0; end
        eh1 = 0; eh2 = 0; uh1 = 0; uh2 = 0;
    endtask

    function automatic longint ref_step(input longint e);
        longint acc, t;
        acc = act[0] * e + act[1] * eh1 + act[2] * eh2;
        t = uh2 + (acc >>> FRAC_W);
        if (t > UMAX) t = UMAX;
        if (t < UMIN) t = UMIN;
        eh2 = eh1; eh1 = e; uh2 = uh1; uh1 = t;
        return t;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk);
        @(negedge clk); rst = 0;
        ref_clear();
        chk(u_valid == 0, "R7 valid after reset", longint'(u_valid), 0);
        chk(u_out == 0, "R7 output after reset", longint'(u_out), 0);
    endtask

    task automatic write_coef(input int sel, input int data);
        @(negedge clk); cf_we = 1; cf_sel = 2'(sel); cf_wdata = 16'(data);
        @(negedge clk); cf_we = 0;
        if (sel < 3) sh[sel] = data;
    endtask

    // one sample; optional same-cycle coefficient write and mid-run strobe poke
    task automatic run_sample(input int e, input bit wr, input int sel, input int data,
                              input bit poke, input string tag);
        longint x;
        @(negedge clk);
        smp_stb = 1; e_in = 16'(e);
        cf_we = wr; cf_sel = 2'(sel); cf_wdata = 16'(data);
        for (int i = 0; i < 3; i++) act[i] = sh[i];
        if (wr && sel < 3) sh[sel] = data;
        x = ref_step(e);
        @(negedge clk); smp_stb = 0; cf_we = 0;
        @(negedge clk);
        if (poke) begin smp_stb = 1; e_in = 16'(e + 999); end
        @(negedge clk); smp_stb = 0;
        @(negedge clk);
        chk(u_valid == 0, {tag, " R5 early valid"}, longint'(u_valid), 0);
        @(negedge clk);
        chk(u_valid == 1, {tag, " R5 valid pulse"}, longint'(u_valid), 1);
        chk(longint'(u_out) == x, {tag, " value"}, longint'(u_out), x);
        @(negedge clk);
        chk(u_valid == 0, {tag, " R5 pulse width"}, longint'(u_valid), 0);
        chk(longint'(u_out) == x, {tag, " R8 hold"}, longint'(u_out), x);
    endtask

    task automatic t_step();
        write_coef(0, 6144); write_coef(1, -4096); write_coef(2, 1024);
        for (int k = 0; k < 5; k++) run_sample(200, 0, 0, 0, 0, "R1 step");
    endtask

    task automatic t_ramp();
        for (int k = 0; k < 6; k++) run_sample(-300 + 130 * k, 0, 0, 0, 0, "R1 ramp");
    endtask

    task automatic t_sat();
        write_coef(0, 32767);
        run_sample(30000, 0, 0, 0, 0, "R2 sat high");
        chk(uh1 == UMAX, "R2 model clamp high", uh1, UMAX);
        for (int k = 0; k < 3; k++) run_sample(0, 0, 0, 0, 0, "R2 feedback after clamp");
        run_sample(-30000, 0, 0, 0, 0, "R2 sat low");
        run_sample(-30000, 0, 0, 0, 0, "R2 sat low again");
        for (int k = 0; k < 2; k++) run_sample(0, 0, 0, 0, 0, "R2 feedback neg");
    endtask

    task automatic t_coef_timing();
        do_reset();
        write_coef(0, 4096);
        run_sample(500, 1, 0, 12000, 0, "R4 same-cycle write");
        run_sample(500, 0, 0, 0, 0, "R4 new coef used");
        write_coef(3, -20000);
        run_sample(-700, 0, 0, 0, 0, "R3 sel3 ignored");
        write_coef(2, -2048);
        run_sample(40, 0, 0, 0, 0, "R3 b2 write");
        run_sample(40, 0, 0, 0, 0, "R3 b2 effect");
    endtask

    task automatic t_busy_strobe();
        run_sample(1000, 0, 0, 0, 1, "R6 strobe while busy");
        run_sample(-250, 0, 0, 0, 0, "R6 history intact");
        run_sample(60, 0, 0, 0, 0, "R6 history intact 2");
    endtask

    task automatic t_reset_mid();
        do_reset();
        run_sample(1234, 0, 0, 0, 0, "R7 coefs cleared");
        write_coef(0, 2048); write_coef(1, 1024);
        run_sample(800, 0, 0, 0, 0, "R7 zero history");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        run_sample(5000, 0, 0, 0, 0, "R7 zero coef output");
        t_step();
        t_ramp();
        t_sat();
        t_coef_timing();
        t_busy_strobe();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule